// File: doc/BRIEF.md
# Global Prefetch Throttle Arbiter

This block sits above the per-core prefetch throttles of a multi-core chip and turns each core's locally proposed aggressiveness change into a final decision that accounts for interference with the other cores. At the end of every sampling interval it takes, for each core, four feedback figures: prefetch accuracy, how many other-core demand lines that core's prefetches evicted and later missed on, the memory bandwidth the core consumed, and the bandwidth the other cores were denied because of it. Each figure is compared with a programmable threshold.

From those four comparisons each core is put in one of three interference classes. Severe interference forces a throttle-down whatever the local controller proposed. Borderline interference lets a throttle-down or a hold through but turns a throttle-up into a hold. With no interference, or only moderate interference from an accurate prefetcher, the local proposal passes unchanged. One registered decision and class per core come out a cycle after the interval-end pulse, with a one-cycle valid strobe.

Top module: `xcore_throttle_arbiter`

## Requirements
- R1: After reset every final action is hold (2'b00), every class is none (2'b00), the valid strobe is low, and the thresholds are accuracy 614 (0.6 in a 10-bit fraction of 1024), pollution 90, bandwidth 50000 and other-core bandwidth need 75000.
- R2: A cycle with intervalEnd high makes decisionValid high for exactly the next cycle; final actions and classes change only on that edge and hold their values otherwise.
- R3: A metric counts as high (accuracy: the prefetcher counts as accurate) when it is greater than or equal to its threshold; one below the threshold counts as low.
- R4: The class is severe (2'b10) and the final action is down when the prefetcher is inaccurate with high pollution, or accurate with high pollution, high bandwidth and high other-core need, or inaccurate with high bandwidth and high other-core need.
- R5: The class is borderline (2'b01) when not severe and either accurate with high pollution, or inaccurate with low pollution, high bandwidth and low other-core need; a local up becomes hold, a local hold or down passes.
- R6: In every other case the class is none (2'b00) and the local action passes unchanged.
- R7: Actions are coded 2'b00 hold, 2'b01 up, 2'b10 down; a local code of 2'b11 is treated as hold, and no output ever carries code 2'b11.
- R8: A threshold write selects accuracy with address 0, pollution 1, bandwidth 2 and other-core need 3; it takes effect at its clock edge, so an evaluation on the same edge still uses the old value.
- R9: Each core's decision depends only on that core's own metrics and local action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intervalEnd | input | 1 | One-cycle pulse: evaluate all cores |
| accuracy | input | NUM_CORES*ACC_W | Per-core accuracy, unsigned fraction of 2^ACC_W |
| pollution | input | NUM_CORES*POL_W | Per-core inter-core pollution count |
| bwUsed | input | NUM_CORES*BW_W | Per-core bandwidth consumed |
| bwOthers | input | NUM_CORES*BW_W | Per-core bandwidth other cores needed |
| localAction | input | NUM_CORES*2 | Per-core local proposal |
| cfgWrEn | input | 1 | Threshold write enable |
| cfgAddr | input | 2 | Threshold select |
| cfgWrData | input | CFG_W | Threshold write value (low bits used) |
| finalAction | output | NUM_CORES*2 | Registered final decision per core |
| interferenceClass | output | NUM_CORES*2 | Registered class per core |
| decisionValid | output | 1 | High one cycle after intervalEnd |

## Verification
Directed intervals place each core on one of the three severe conditions, the two borderline conditions and the pass-through cases at once, which tells apart a wrong classification from a wrong muxing of the local proposal and shows cores do not leak into each other. Metrics exactly at and one below each threshold separate greater-or-equal from strictly-greater comparison. A threshold write on the same edge as an interval end distinguishes old-value from new-value evaluation, and a long run of random metrics clustered around the thresholds, with random local codes including 2'b11 and occasional writes, is compared every cycle with a behavioural model.

// File: rtl/xta_pkg.sv
package xta_pkg;
  localparam logic [1:0] ACT_HOLD = 2'b00;
  localparam logic [1:0] ACT_UP   = 2'b01;
  localparam logic [1:0] ACT_DOWN = 2'b10;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'b00,
    CLS_BORDER = 2'b01,
    CLS_SEVERE = 2'b10
  } cls_e;

  localparam int THR_COUNT = 4;
  localparam int THR_SEL_W = $clog2(THR_COUNT);
  localparam int THR_ACC   = 0;
  localparam int THR_POL   = 1;
  localparam int THR_BW    = 2;
  localparam int THR_BWNO  = 3;

  typedef struct packed {
    logic [THR_COUNT-1:0] thrLoad;
    logic                 capture;
  } xta_strobe_t;
endpackage

// File: rtl/xta_core_judge.sv
module xta_core_judge
  import xta_pkg::*;
#(
  parameter int ACC_W = 10,
  parameter int POL_W = 16,
  parameter int BW_W  = 20
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [POL_W-1:0] pol,
  input  logic [BW_W-1:0]  bw,
  input  logic [BW_W-1:0]  bwno,
  input  logic [ACC_W-1:0] accThr,
  input  logic [POL_W-1:0] polThr,
  input  logic [BW_W-1:0]  bwThr,
  input  logic [BW_W-1:0]  bwnoThr,
  input  logic [1:0]       localAct,
  output cls_e             cls,
  output logic [1:0]       action
);
  logic accurate, highPol, highBw, highBwno;
  logic severe, border;
  logic [1:0] localNorm;

  assign accurate = (acc >= accThr);
  assign highPol  = (pol >= polThr);
  assign highBw   = (bw >= bwThr);
  assign highBwno = (bwno >= bwnoThr);

  assign severe = (!accurate && highPol)
               || (accurate && highPol && highBw && highBwno)
               || (!accurate && highBw && highBwno);

  assign border = !severe
               && ((accurate && highPol)
                || (!accurate && !highPol && highBw && !highBwno));

  assign localNorm = (localAct == 2'b11) ? ACT_HOLD : localAct;

  always_comb begin
    if (severe) begin
      cls    = CLS_SEVERE;
      action = ACT_DOWN;
    end else if (border) begin
      cls    = CLS_BORDER;
      action = (localNorm == ACT_UP) ? ACT_HOLD : localNorm;
    end else begin
      cls    = CLS_NONE;
      action = localNorm;
    end
  end
endmodule

// File: rtl/xta_control.sv
module xta_control
  import xta_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 intervalEnd,
  input  logic                 cfgWrEn,
  input  logic [THR_SEL_W-1:0] cfgAddr,
  output xta_strobe_t          strobe,
  output logic                 decisionValid
);
  for (genvar k = 0; k < THR_COUNT; k++) begin : g_load
    assign strobe.thrLoad[k] = cfgWrEn && (cfgAddr == THR_SEL_W'(k));
  end
  assign strobe.capture = intervalEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) decisionValid <= 1'b0;
    else       decisionValid <= intervalEnd;
  end
endmodule

// File: rtl/xta_datapath.sv
module xta_datapath
  import xta_pkg::*;
#(
  parameter int NUM_CORES    = 4,
  parameter int ACC_W        = 10,
  parameter int POL_W        = 16,
  parameter int BW_W         = 20,
  parameter int CFG_W        = 32,
  parameter int ACC_THR_DEF  = 614,
  parameter int POL_THR_DEF  = 90,
  parameter int BW_THR_DEF   = 50000,
  parameter int BWNO_THR_DEF = 75000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  xta_strobe_t              strobe,
  input  logic [CFG_W-1:0]         cfgWrData,
  input  logic [NUM_CORES*ACC_W-1:0] accuracy,
  input  logic [NUM_CORES*POL_W-1:0] pollution,
  input  logic [NUM_CORES*BW_W-1:0]  bwUsed,
  input  logic [NUM_CORES*BW_W-1:0]  bwOthers,
  input  logic [NUM_CORES*2-1:0]     localAction,
  output logic [NUM_CORES*2-1:0]     finalAction,
  output logic [NUM_CORES*2-1:0]     interferenceClass
);
  logic [ACC_W-1:0] accThr;
  logic [POL_W-1:0] polThr;
  logic [BW_W-1:0]  bwThr;
  logic [BW_W-1:0]  bwnoThr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accThr  <= ACC_W'(ACC_THR_DEF);
      polThr  <= POL_W'(POL_THR_DEF);
      bwThr   <= BW_W'(BW_THR_DEF);
      bwnoThr <= BW_W'(BWNO_THR_DEF);
    end else begin
      if (strobe.thrLoad[THR_ACC])  accThr  <= cfgWrData[ACC_W-1:0];
      if (strobe.thrLoad[THR_POL])  polThr  <= cfgWrData[POL_W-1:0];
      if (strobe.thrLoad[THR_BW])   bwThr   <= cfgWrData[BW_W-1:0];
      if (strobe.thrLoad[THR_BWNO]) bwnoThr <= cfgWrData[BW_W-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    cls_e       coreCls;
    logic [1:0] coreAct;

    xta_core_judge #(.ACC_W(ACC_W), .POL_W(POL_W), .BW_W(BW_W)) i_judge (
      .acc      (accuracy[c*ACC_W +: ACC_W]),
      .pol      (pollution[c*POL_W +: POL_W]),
      .bw       (bwUsed[c*BW_W +: BW_W]),
      .bwno     (bwOthers[c*BW_W +: BW_W]),
      .accThr   (accThr),
      .polThr   (polThr),
      .bwThr    (bwThr),
      .bwnoThr  (bwnoThr),
      .localAct (localAction[c*2 +: 2]),
      .cls      (coreCls),
      .action   (coreAct)
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        finalAction[c*2 +: 2]       <= ACT_HOLD;
        interferenceClass[c*2 +: 2] <= CLS_NONE;
      end else if (strobe.capture) begin
        finalAction[c*2 +: 2]       <= coreAct;
        interferenceClass[c*2 +: 2] <= coreCls;
      end
    end
  end
endmodule

// File: rtl/xcore_throttle_arbiter.sv
module xcore_throttle_arbiter
  import xta_pkg::*;
#(
  parameter int NUM_CORES    = 4,
  parameter int ACC_W        = 10,
  parameter int POL_W        = 16,
  parameter int BW_W         = 20,
  parameter int CFG_W        = 32,
  parameter int ACC_THR_DEF  = 614,
  parameter int POL_THR_DEF  = 90,
  parameter int BW_THR_DEF   = 50000,
  parameter int BWNO_THR_DEF = 75000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       intervalEnd,
  input  logic [NUM_CORES*ACC_W-1:0] accuracy,
  input  logic [NUM_CORES*POL_W-1:0] pollution,
  input  logic [NUM_CORES*BW_W-1:0]  bwUsed,
  input  logic [NUM_CORES*BW_W-1:0]  bwOthers,
  input  logic [NUM_CORES*2-1:0]     localAction,
  input  logic                       cfgWrEn,
  input  logic [1:0]                 cfgAddr,
  input  logic [CFG_W-1:0]           cfgWrData,
  output logic [NUM_CORES*2-1:0]     finalAction,
  output logic [NUM_CORES*2-1:0]     interferenceClass,
  output logic                       decisionValid
);
  xta_strobe_t strobe;

  xta_control i_control (
    .clk           (clk),
    .rstN          (rstN),
    .intervalEnd   (intervalEnd),
    .cfgWrEn       (cfgWrEn),
    .cfgAddr       (cfgAddr),
    .strobe        (strobe),
    .decisionValid (decisionValid)
  );

  xta_datapath #(
    .NUM_CORES(NUM_CORES), .ACC_W(ACC_W), .POL_W(POL_W), .BW_W(BW_W),
    .CFG_W(CFG_W), .ACC_THR_DEF(ACC_THR_DEF), .POL_THR_DEF(POL_THR_DEF),
    .BW_THR_DEF(BW_THR_DEF), .BWNO_THR_DEF(BWNO_THR_DEF)
  ) i_datapath (
    .clk               (clk),
    .rstN              (rstN),
    .strobe            (strobe),
    .cfgWrData         (cfgWrData),
    .accuracy          (accuracy),
    .pollution         (pollution),
    .bwUsed            (bwUsed),
    .bwOthers          (bwOthers),
    .localAction       (localAction),
    .finalAction       (finalAction),
    .interferenceClass (interferenceClass)
  );
endmodule

// File: rtl/xta_checker.sv
module xta_checker #(
  parameter int NUM_CORES = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   intervalEnd,
  input logic [NUM_CORES*2-1:0] localAction,
  input logic [NUM_CORES*2-1:0] finalAction,
  input logic [NUM_CORES*2-1:0] interferenceClass,
  input logic                   decisionValid
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    intervalEnd |=> decisionValid);

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    !intervalEnd |=> !decisionValid);

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rstN)
    !intervalEnd |=> ($stable(finalAction) && $stable(interferenceClass)));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    assert_severe_down_R4: assert property (@(posedge clk) disable iff (!rstN)
      (decisionValid && interferenceClass[c*2 +: 2] == 2'b10)
        |-> finalAction[c*2 +: 2] == 2'b10);

    assert_border_no_up_R5: assert property (@(posedge clk) disable iff (!rstN)
      (decisionValid && interferenceClass[c*2 +: 2] == 2'b01)
        |-> finalAction[c*2 +: 2] != 2'b01);

    assert_none_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
      (decisionValid && interferenceClass[c*2 +: 2] == 2'b00
        && $past(localAction[c*2 +: 2]) != 2'b11)
        |-> finalAction[c*2 +: 2] == $past(localAction[c*2 +: 2]));

    assert_codes_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
      decisionValid |-> (finalAction[c*2 +: 2] != 2'b11
                         && interferenceClass[c*2 +: 2] != 2'b11));
  end
endmodule

bind xcore_throttle_arbiter xta_checker #(.NUM_CORES(NUM_CORES)) i_xta_checker (
  .clk               (clk),
  .rstN              (rstN),
  .intervalEnd       (intervalEnd),
  .localAction       (localAction),
  .finalAction       (finalAction),
  .interferenceClass (interferenceClass),
  .decisionValid     (decisionValid)
);

// File: tb/test_xcore_throttle_arbiter.sv
module test_xcore_throttle_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NC    = 4;
  localparam int ACC_W = 10;
  localparam int POL_W = 16;
  localparam int BW_W  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intervalEnd = 1'b0;
  logic [NC*ACC_W-1:0] accuracy = '0;
  logic [NC*POL_W-1:0] pollution = '0;
  logic [NC*BW_W-1:0]  bwUsed = '0;
  logic [NC*BW_W-1:0]  bwOthers = '0;
  logic [NC*2-1:0]     localAction = '0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [NC*2-1:0] finalAction;
  logic [NC*2-1:0] interferenceClass;
  logic decisionValid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  xcore_throttle_arbiter i_xcore_throttle_arbiter (
    .clk(clk), .rstN(rstN), .intervalEnd(intervalEnd),
    .accuracy(accuracy), .pollution(pollution), .bwUsed(bwUsed),
    .bwOthers(bwOthers), .localAction(localAction),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .finalAction(finalAction), .interferenceClass(interferenceClass),
    .decisionValid(decisionValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int mThr[4];
  int expAct[NC];
  int expCls[NC];
  int expValid;

  function automatic void judge(input int acc, input int pol, input int bw,
                                input int bwno, input int loc,
                                output int cls, output int act);
    bit good, pHi, bHi, nHi;
    int l;
    good = acc >= mThr[0];
    pHi  = pol >= mThr[1];
    bHi  = bw >= mThr[2];
    nHi  = bwno >= mThr[3];
    l = (loc == 3) ? 0 : loc;
    if ((!good && pHi) || (good && pHi && bHi && nHi) || (!good && bHi && nHi)) begin
      cls = 2; act = 2;
    end else if ((good && pHi) || (!good && !pHi && bHi && !nHi)) begin
      cls = 1; act = (l == 1) ? 0 : l;
    end else begin
      cls = 0; act = l;
    end
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      expValid = 0;
      mThr[0] = 614; mThr[1] = 90; mThr[2] = 50000; mThr[3] = 75000;
      for (int c = 0; c < NC; c++) begin expAct[c] = 0; expCls[c] = 0; end
    end else begin
      expValid = intervalEnd ? 1 : 0;
      if (intervalEnd)
        for (int c = 0; c < NC; c++)
          judge(int'(accuracy[c*ACC_W +: ACC_W]), int'(pollution[c*POL_W +: POL_W]),
                int'(bwUsed[c*BW_W +: BW_W]), int'(bwOthers[c*BW_W +: BW_W]),
                int'(localAction[c*2 +: 2]), expCls[c], expAct[c]);
      if (cfgWrEn) begin
        case (cfgAddr)
          2'd0: mThr[0] = int'(cfgWrData[ACC_W-1:0]);
          2'd1: mThr[1] = int'(cfgWrData[POL_W-1:0]);
          2'd2: mThr[2] = int'(cfgWrData[BW_W-1:0]);
          default: mThr[3] = int'(cfgWrData[BW_W-1:0]);
        endcase
      end
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      string tag;
      checks++;
      if (int'(decisionValid) != expValid) begin
        failures++;
        $display("FAIL %s valid got %0d exp %0d", rstN ? "R2" : "R1", decisionValid, expValid);
      end
      for (int c = 0; c < NC; c++) begin
        if (!rstN) tag = "R1";
        else if (expCls[c] == 2) tag = "R4";
        else if (expCls[c] == 1) tag = "R5";
        else tag = "R6";
        checks++;
        if (int'(finalAction[c*2 +: 2]) != expAct[c] ||
            int'(interferenceClass[c*2 +: 2]) != expCls[c]) begin
          failures++;
          $display("FAIL %s core %0d act/cls got %0d/%0d exp %0d/%0d", tag, c,
                   finalAction[c*2 +: 2], interferenceClass[c*2 +: 2], expAct[c], expCls[c]);
        end
      end
    end
  end

  // Hand-computed directed checks
  task automatic expectCore(input int c, input int act, input int cls, input string tag);
    checks++;
    if (int'(finalAction[c*2 +: 2]) != act || int'(interferenceClass[c*2 +: 2]) != cls) begin
      failures++;
      $display("FAIL %s core %0d act/cls got %0d/%0d exp %0d/%0d", tag, c,
               finalAction[c*2 +: 2], interferenceClass[c*2 +: 2], act, cls);
    end
  endtask

  task automatic setCore(input int c, input int acc, input int pol, input int bw,
                         input int bwno, input int loc);
    accuracy[c*ACC_W +: ACC_W] = ACC_W'(acc);
    pollution[c*POL_W +: POL_W] = POL_W'(pol);
    bwUsed[c*BW_W +: BW_W] = BW_W'(bw);
    bwOthers[c*BW_W +: BW_W] = BW_W'(bwno);
    localAction[c*2 +: 2] = 2'(loc);
  endtask

  task automatic runInterval();
    @(posedge clk); #1 intervalEnd = 1'b1;
    @(posedge clk); #1 intervalEnd = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfgWrite(input int addr, input int data);
    @(posedge clk); #1 cfgWrEn = 1'b1; cfgAddr = 2'(addr); cfgWrData = 32'(data);
    @(posedge clk); #1 cfgWrEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    expectCore(0, 0, 0, "R1");
    checks++;
    if (decisionValid !== 1'b0) begin
      failures++;
      $display("FAIL R1 valid got %0d exp 0", decisionValid);
    end
    @(posedge clk); #1 rstN = 1'b1;
    repeat (2) @(posedge clk);

    // R4 severe cases; core3 accurate with heavy bandwidth passes (R6); R9 mixed cores
    setCore(0, 100, 200, 0, 0, 1);
    setCore(1, 900, 200, 60000, 80000, 1);
    setCore(2, 100, 0, 60000, 80000, 0);
    setCore(3, 900, 0, 60000, 80000, 1);
    runInterval();
    expectCore(0, 2, 2, "R4");
    expectCore(1, 2, 2, "R4");
    expectCore(2, 2, 2, "R4");
    expectCore(3, 1, 0, "R6_R9");
    @(negedge clk);
    checks++;
    if (decisionValid !== 1'b0) begin
      failures++;
      $display("FAIL R2 valid not a pulse got %0d exp 0", decisionValid);
    end

    // R2: changing inputs without interval end changes nothing
    setCore(0, 900, 0, 0, 0, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    expectCore(0, 2, 2, "R2");

    // R5 borderline cases
    setCore(0, 900, 200, 0, 0, 1);
    setCore(1, 900, 200, 0, 0, 2);
    setCore(2, 100, 0, 60000, 0, 1);
    setCore(3, 100, 0, 0, 0, 1);
    runInterval();
    expectCore(0, 0, 1, "R5");
    expectCore(1, 2, 1, "R5");
    expectCore(2, 0, 1, "R5");
    expectCore(3, 1, 0, "R6");

    // R3 boundaries at default thresholds (R1), R7 local code 3
    setCore(0, 613, 90, 0, 0, 1);
    setCore(1, 614, 89, 50000, 75000, 2);
    setCore(2, 614, 90, 49999, 75000, 1);
    setCore(3, 100, 0, 0, 0, 3);
    runInterval();
    expectCore(0, 2, 2, "R3");
    expectCore(1, 2, 0, "R3");
    expectCore(2, 0, 1, "R3");
    expectCore(3, 0, 0, "R7");

    // R8: write on the same edge as interval end uses the old threshold
    setCore(0, 100, 200, 0, 0, 1);
    @(posedge clk); #1 intervalEnd = 1'b1; cfgWrEn = 1'b1; cfgAddr = 2'd1; cfgWrData = 32'd300;
    @(posedge clk); #1 intervalEnd = 1'b0; cfgWrEn = 1'b0;
    @(negedge clk);
    expectCore(0, 2, 2, "R8");
    runInterval();
    expectCore(0, 1, 0, "R8");
    cfgWrite(0, 50);
    setCore(0, 100, 400, 0, 0, 1);
    runInterval();
    expectCore(0, 0, 1, "R8");
    cfgWrite(0, 614);
    cfgWrite(1, 90);

    // Random intervals around thresholds, compared by the model
    for (int n = 0; n < 400; n++) begin
      for (int c = 0; c < NC; c++)
        setCore(c, int'($urandom_range(1023)), int'($urandom_range(180)),
                int'($urandom_range(100000)), int'($urandom_range(150000)),
                int'($urandom_range(3)));
      if ($urandom_range(9) == 0)
        cfgWrite(int'($urandom_range(3)), int'($urandom_range(1000)) +
                 (($urandom_range(1) == 1) ? 50000 : 0));
      if ($urandom_range(3) == 0) begin
        @(posedge clk); #1 intervalEnd = 1'b1; cfgWrEn = 1'b1;
        cfgAddr = 2'($urandom_range(3)); cfgWrData = 32'($urandom_range(700));
        @(posedge clk); #1 intervalEnd = 1'b0; cfgWrEn = 1'b0;
      end else begin
        runInterval();
      end
      repeat (int'($urandom_range(2))) @(posedge clk);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule